// File: doc/BRIEF.md
# Multi-channel phased PWM generator

This block turns eighteen 8-bit brightness codes into eighteen on/off gate signals for constant-current LED sinks. All channels share one free-running 8-bit frame counter, so every channel window is aligned to the same frame. A prescaler ahead of the counter sets how often it advances. A rate select of 0 advances it every `FAST_DIV` clocks, which is the fast frame. A rate select of 1 advances it every `SLOW_DIV` clocks, which is the slow frame. The default ratio is 125:1, the ratio between a 25 kHz frame and a 200 Hz frame.

Each channel compares its duty code against the frame position. A per-channel full-on bit overrides the comparison. With the phase feature enabled, selected pairs of adjacent channels compare against the position advanced by half a frame, which spreads their switching across the period. Duty codes are copied into per-channel shadow registers only at the frame boundary.

A per-channel handshake sets the cycle at which newly requested current-scaling values may be applied. It issues a one-clock strobe for each channel. The strobe falls on the channel's falling gate edge in the frame after the request. It comes at once when the channel is full-on or the block is halted. A global halt input forces every gate low.

The frame timebase is a state machine with three states. HALT holds the counter at zero. PRIME loads the duty shadows. RUN advances the counter. Its transitions are: HALT to PRIME when halt is low; PRIME to RUN unconditionally; any state to HALT when halt is high.

Each channel's scaling handshake is a state machine with three states: IDLE, PEND and READY. Its transitions are:
- IDLE to PEND on a request.
- PEND to READY at a frame wrap.
- PEND or READY back to PEND on a new request.
- PEND or READY to IDLE with a strobe when the channel is full-on or the timebase is not in RUN.
- READY to IDLE with a strobe on a falling gate edge, or when the channel's shadow duty is zero.

Top module: `pwmph_top`

## Requirements
- R1: With duty code N on a channel that is not full-on, its gate is high for exactly N×D clocks of every frame of 256×D clocks, where D is the active divider; code 0 keeps the gate low and code 255 gives 255×D high clocks.
- R2: Rate select 0 gives D = FAST_DIV and rate select 1 gives D = SLOW_DIV; the frame counter advances only on a prescaler tick.
- R3: A channel whose full-on bit (dc_mask[i]) is 1 holds its gate high for every clock of the frame, whatever its duty code.
- R4: With phase_en = 1, phase_sel[k] = 1 shifts channels 2k and 2k+1 (zero-based) by 128 counter steps; both channels of a pair share one bit, and a shifted channel keeps its high-time count.
- R5: With phase_en = 0, all channels are unshifted whatever phase_sel holds.
- R6: A duty code change takes effect only at the next frame boundary; the pulse in progress keeps its old length.
- R7: After a scale_req pulse, a channel in PWM operation strobes scale_load[i] for one clock, on the clock its gate goes low, in the frame after the request frame; its first falling edge after the request is skipped. A channel whose shadow duty is 0 strobes shortly after that frame boundary instead.
- R8: A full-on channel, or any channel while the block is halted, strobes scale_load[i] on the second clock after scale_req is sampled.
- R9: Halt forces every gate low, including full-on channels, from the second clock after it is sampled; on release the frame restarts and duty operation resumes.
- R10: During reset all gates and all scale_load strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Global shutdown; forces all gates low |
| rate_sel | input | 1 | 0 = fast frame, 1 = slow frame |
| duty_in | input | NUM_CH×DUTY_W | Duty codes, channel i at bits [i×DUTY_W +: DUTY_W] |
| dc_mask | input | NUM_CH | Per-channel full-on override |
| phase_en | input | 1 | Enables the half-frame pair shift |
| phase_sel | input | (NUM_CH+1)/2 | Bit k shifts channels 2k and 2k+1 |
| scale_req | input | 1 | Request to apply new current-scaling values |
| gate | output | NUM_CH | Channel on/off enables |
| scale_load | output | NUM_CH | One-clock per-channel strobe for applying scaling |

## Verification
A gate reflects the frame counter one clock after the counter, so high-time is measured over a full-frame window. The window opens only after two frame lengths of settling, which covers the wait for the duty shadows to reload at a frame boundary. A frame-length window makes the count independent of where the window starts.

Because duty changes wait for the boundary, the check for R6 measures the pulse in progress directly. It starts at a rising edge of the gate and counts until the next falling edge.

Strobe timing is checked on fixed clocks. A full-on or halted channel must strobe exactly on the second falling clock edge after the request is driven, and not on the first or third. A PWM channel's strobe must coincide with its second observed falling gate edge, counted from the request issued just after a frame start. Halt is checked on the second falling clock edge after it is driven, which matches the timebase state register and the gate register it passes through.

// File: rtl/pwmph_pkg.sv
package pwmph_pkg;

    // frame timebase control states
    typedef enum logic [1:0] {
        TB_HALT  = 2'd0,
        TB_PRIME = 2'd1,
        TB_RUN   = 2'd2
    } tb_state_e;

    // per-channel scaling-apply handshake states
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_PEND  = 2'd1,
        SC_READY = 2'd2
    } sc_state_e;

endpackage

// File: rtl/pwmph_timebase.sv
module pwmph_timebase
    import pwmph_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 125
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt,
    input  logic             rate_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             tick,
    output logic             wrap,
    output logic             load,
    output logic             run
);

    localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int PRE_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
    localparam logic [PRE_W-1:0] FAST_LIM = PRE_W'(FAST_DIV - 1);
    localparam logic [PRE_W-1:0] SLOW_LIM = PRE_W'(SLOW_DIV - 1);

    tb_state_e        state, state_nx;
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] pre_lim;

    assign pre_lim = rate_sel ? SLOW_LIM : FAST_LIM;
    assign run     = (state == TB_RUN);
    assign load    = (state == TB_PRIME);
    assign tick    = run && (pre >= pre_lim);
    assign wrap    = tick && (cnt == {CNT_W{1'b1}});

    always_comb begin
        state_nx = state;
        unique case (state)
            TB_HALT:  if (!halt) state_nx = TB_PRIME;
            TB_PRIME: state_nx = halt ? TB_HALT : TB_RUN;
            TB_RUN:   if (halt) state_nx = TB_HALT;
            default:  state_nx = TB_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TB_HALT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
            cnt <= '0;
        end else if (state != TB_RUN) begin
            pre <= '0;
            cnt <= '0;
        end else if (tick) begin
            pre <= '0;
            cnt <= cnt + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

endmodule

// File: rtl/pwmph_chan.sv
module pwmph_chan
    import pwmph_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic              wrap,
    input  logic              req,
    input  logic [DUTY_W-1:0] cnt,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              dc,
    input  logic              shift,
    output logic              gate,
    output logic              strobe,
    output logic [DUTY_W-1:0] duty_q
);

    localparam logic [DUTY_W-1:0] HALF = {1'b1, {(DUTY_W-1){1'b0}}};

    sc_state_e         st, st_nx;
    logic [DUTY_W-1:0] pos;
    logic              on_nx;
    logic              fall_nx;
    logic              fire;

    // half-frame shift: position advanced by 128 steps, modulo 256
    assign pos     = shift ? (cnt + HALF) : cnt;
    assign on_nx   = run && (dc || (pos < duty_q));
    assign fall_nx = gate && !on_nx;

    // shadow duty: only reloaded at frame start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            duty_q <= '0;
        else if (load || wrap) duty_q <= duty_in;
    end

    always_comb begin
        st_nx = st;
        fire  = 1'b0;
        unique case (st)
            SC_IDLE: begin
                if (req) st_nx = SC_PEND;
            end
            SC_PEND: begin
                if (req) begin
                    st_nx = SC_PEND;
                end else if (dc || !run) begin
                    fire  = 1'b1;
                    st_nx = SC_IDLE;
                end else if (wrap) begin
                    st_nx = SC_READY;
                end
            end
            SC_READY: begin
                if (req) begin
                    st_nx = SC_PEND;
                end else if (dc || !run || fall_nx || (duty_q == '0)) begin
                    fire  = 1'b1;
                    st_nx = SC_IDLE;
                end
            end
            default: st_nx = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SC_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate   <= 1'b0;
            strobe <= 1'b0;
        end else begin
            gate   <= on_nx;
            strobe <= fire;
        end
    end

endmodule

// File: rtl/pwmph_top.sv
module pwmph_top
    import pwmph_pkg::*;
#(
    parameter int NUM_CH   = 18,
    parameter int DUTY_W   = 8,
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 125
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       halt,
    input  logic                       rate_sel,
    input  logic [NUM_CH*DUTY_W-1:0]   duty_in,
    input  logic [NUM_CH-1:0]          dc_mask,
    input  logic                       phase_en,
    input  logic [(NUM_CH+1)/2-1:0]    phase_sel,
    input  logic                       scale_req,
    output logic [NUM_CH-1:0]          gate,
    output logic [NUM_CH-1:0]          scale_load
);

    localparam int NUM_PAIR = (NUM_CH + 1) / 2;

    logic [DUTY_W-1:0]        cnt;
    logic                     tick;
    logic                     wrap;
    logic                     load;
    logic                     run;
    logic [NUM_CH*DUTY_W-1:0] duty_sh;
    logic [NUM_PAIR-1:0]      pair_shift;

    assign pair_shift = phase_en ? phase_sel : '0;

    pwmph_timebase #(
        .CNT_W    (DUTY_W),
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (halt),
        .rate_sel (rate_sel),
        .cnt      (cnt),
        .tick     (tick),
        .wrap     (wrap),
        .load     (load),
        .run      (run)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwmph_chan #(
            .DUTY_W (DUTY_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .load    (load),
            .wrap    (wrap),
            .req     (scale_req),
            .cnt     (cnt),
            .duty_in (duty_in[i*DUTY_W +: DUTY_W]),
            .dc      (dc_mask[i]),
            .shift   (pair_shift[i/2]),
            .gate    (gate[i]),
            .strobe  (scale_load[i]),
            .duty_q  (duty_sh[i*DUTY_W +: DUTY_W])
        );
    end

endmodule

// File: rtl/pwmph_checker.sv
module pwmph_checker #(
    parameter int NUM_CH = 18,
    parameter int DUTY_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     halt,
    input logic [NUM_CH-1:0]        dc_mask,
    input logic [NUM_CH-1:0]        gate,
    input logic [NUM_CH-1:0]        scale_load,
    input logic                     run,
    input logic                     tick,
    input logic                     wrap,
    input logic                     load,
    input logic [DUTY_W-1:0]        cnt,
    input logic [NUM_CH*DUTY_W-1:0] duty_sh
);

    logic [NUM_CH-1:0] zero_mask;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_z
        assign zero_mask[i] = (duty_sh[i*DUTY_W +: DUTY_W] == '0);
    end

    // R1: a zero shadow duty never drives its gate high
    p_zero_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> ((gate & $past(zero_mask & ~dc_mask)) == '0));

    // R2: the frame counter only moves on a prescaler tick
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$past(tick)) |-> $stable(cnt));

    // R3: full-on channels are high while running
    p_dc_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> ((gate & $past(dc_mask)) == $past(dc_mask)));

    // R6: shadows change only at frame start
    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wrap) && !$past(load)) |-> $stable(duty_sh));

    // R7: a PWM-mode strobe never coincides with a high gate
    p_strobe_gate_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> ((scale_load & ~$past(dc_mask) & gate) == '0));

    // R9: two clocks of halt leave every gate low
    p_halt_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt, 2) |-> (gate == '0));

endmodule

bind pwmph_top pwmph_checker #(
    .NUM_CH (NUM_CH),
    .DUTY_W (DUTY_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt       (halt),
    .dc_mask    (dc_mask),
    .gate       (gate),
    .scale_load (scale_load),
    .run        (run),
    .tick       (tick),
    .wrap       (wrap),
    .load       (load),
    .cnt        (cnt),
    .duty_sh    (duty_sh)
);

// File: tb/tb_pwmph_top.sv
`timescale 1ns/1ps
module tb_pwmph_top;

    localparam int NCH  = 18;
    localparam int DW   = 8;
    localparam int NP   = (NCH + 1) / 2;
    localparam int SDIV = 3;
    localparam int FLEN = 256;
    localparam int SLEN = 256 * SDIV;

    // {rate_sel, dc on even channels, base duty for channel 0}
    localparam logic [9:0] VEC [0:6] = '{
        {1'b0, 1'b0, 8'd0},
        {1'b0, 1'b0, 8'd1},
        {1'b0, 1'b0, 8'd128},
        {1'b0, 1'b0, 8'd255},
        {1'b1, 1'b0, 8'd37},
        {1'b1, 1'b1, 8'd200},
        {1'b0, 1'b1, 8'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              halt = 1'b0;
    logic              rate_sel = 1'b0;
    logic [NCH*DW-1:0] duty_in = '0;
    logic [NCH-1:0]    dc_mask = '0;
    logic              phase_en = 1'b0;
    logic [NP-1:0]     phase_sel = '0;
    logic              scale_req = 1'b0;
    logic [NCH-1:0]    gate;
    logic [NCH-1:0]    scale_load;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int hi_cnt [NCH];
    int ovl01;
    int ovl02;

    always #2.5 clk = ~clk;

    pwmph_top #(
        .NUM_CH   (NCH),
        .DUTY_W   (DW),
        .FAST_DIV (1),
        .SLOW_DIV (SDIV)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt       (halt),
        .rate_sel   (rate_sel),
        .duty_in    (duty_in),
        .dc_mask    (dc_mask),
        .phase_en   (phase_en),
        .phase_sel  (phase_sel),
        .scale_req  (scale_req),
        .gate       (gate),
        .scale_load (scale_load)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_duty(input int ch, input int v);
        duty_in[ch*DW +: DW] = v[DW-1:0];
    endtask

    task automatic window(input int len);
        for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
        ovl01 = 0;
        ovl02 = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) hi_cnt[c] += int'(gate[c]);
            ovl01 += int'(gate[0] & gate[1]);
            ovl02 += int'(gate[0] & gate[2]);
        end
    endtask

    task automatic wait_rise0();
        logic p;
        bit   seen;
        p = gate[0];
        seen = 1'b0;
        while (!seen) begin
            @(negedge clk);
            if (!p && gate[0]) seen = 1'b1;
            p = gate[0];
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(gate == '0, "R10", "gates in reset", int'(gate), 0);
        chk(scale_load == '0, "R10", "strobes in reset", int'(scale_load), 0);
        rst_n = 1'b1;

        // table walk: R1 / R2 / R3 high-time per frame
        for (int v = 0; v < 7; v++) begin
            logic [9:0] e;
            int len;
            int div;
            e = VEC[v];
            rate_sel = e[9];
            len = e[9] ? SLEN : FLEN;
            div = e[9] ? SDIV : 1;
            for (int c = 0; c < NCH; c++) begin
                set_duty(c, (int'(e[7:0]) + 13 * c) % 256);
                dc_mask[c] = e[8] && (c % 2 == 0);
            end
            repeat (3 * len) @(negedge clk);
            window(len);
            for (int c = 0; c < NCH; c++) begin
                int exp;
                string tag;
                if (dc_mask[c]) begin
                    exp = len;
                    tag = "R3";
                end else begin
                    exp = ((int'(e[7:0]) + 13 * c) % 256) * div;
                    tag = e[9] ? "R2" : "R1";
                end
                chk(hi_cnt[c] == exp, tag, $sformatf("vec %0d ch %0d high count", v, c),
                    hi_cnt[c], exp);
            end
        end

        // R4: pair 1 (channels 2,3) shifted by half a frame
        rate_sel = 1'b0;
        dc_mask = '0;
        for (int c = 0; c < NCH; c++) set_duty(c, 128);
        phase_en = 1'b1;
        phase_sel = NP'(2);
        repeat (3 * FLEN) @(negedge clk);
        window(FLEN);
        chk(ovl02 == 0, "R4", "ch0/ch2 overlap, ch2 shifted", ovl02, 0);
        chk(ovl01 == 128, "R4", "ch0/ch1 overlap, same pair", ovl01, 128);
        chk(hi_cnt[2] == 128, "R4", "shifted ch2 high count", hi_cnt[2], 128);
        chk(hi_cnt[3] == 128, "R4", "shifted ch3 high count", hi_cnt[3], 128);

        // R4: shifting pair 0 too brings ch0 and ch2 back into step
        phase_sel = NP'(3);
        repeat (3 * FLEN) @(negedge clk);
        window(FLEN);
        chk(ovl02 == 128, "R4", "ch0/ch2 overlap, both shifted", ovl02, 128);
        chk(ovl01 == 128, "R4", "ch0/ch1 overlap, pair shifted together", ovl01, 128);

        // R5: phase disabled ignores phase_sel
        phase_sel = NP'(2);
        phase_en = 1'b0;
        repeat (3 * FLEN) @(negedge clk);
        window(FLEN);
        chk(ovl02 == 128, "R5", "ch0/ch2 overlap with phase off", ovl02, 128);

        // R6: duty change mid-pulse waits for the frame boundary
        begin
            int plen;
            bit hi;
            set_duty(0, 64);
            repeat (3 * FLEN) @(negedge clk);
            wait_rise0();
            plen = 1;
            hi = 1'b1;
            while (hi) begin
                @(negedge clk);
                if (plen == 10) set_duty(0, 200);
                if (gate[0]) plen++;
                else hi = 1'b0;
            end
            chk(plen == 64, "R6", "pulse in progress keeps old duty", plen, 64);
            wait_rise0();
            plen = 1;
            hi = 1'b1;
            while (hi) begin
                @(negedge clk);
                if (gate[0]) plen++;
                else hi = 1'b0;
            end
            chk(plen == 200, "R6", "next frame uses new duty", plen, 200);
        end

        // R7: strobe on the falling edge in the frame after the request
        begin
            int falls;
            int n0;
            int fall_at;
            int n4;
            bit p;
            set_duty(0, 64);
            set_duty(4, 0);
            repeat (3 * FLEN) @(negedge clk);
            wait_rise0();
            scale_req = 1'b1;
            p = gate[0];
            falls = 0;
            n0 = 0;
            fall_at = -1;
            n4 = 0;
            for (int k = 0; k < 3 * FLEN; k++) begin
                @(negedge clk);
                scale_req = 1'b0;
                if (p && !gate[0]) falls++;
                if (scale_load[0]) begin
                    n0++;
                    fall_at = (p && !gate[0]) ? falls : -1;
                end
                if (scale_load[4]) n4++;
                p = gate[0];
            end
            chk(n0 == 1, "R7", "ch0 strobe count", n0, 1);
            chk(fall_at == 2, "R7", "ch0 strobe at second falling edge", fall_at, 2);
            chk(n4 == 1, "R7", "zero-duty ch4 strobe count", n4, 1);
        end

        // R8: full-on channel strobes two clocks after the request
        dc_mask = NCH'(1) << 2;
        repeat (4) @(negedge clk);
        scale_req = 1'b1;
        @(negedge clk);
        scale_req = 1'b0;
        chk(scale_load[2] == 1'b0, "R8", "dc ch2 strobe one clock after", int'(scale_load[2]), 0);
        @(negedge clk);
        chk(scale_load[2] == 1'b1, "R8", "dc ch2 strobe two clocks after", int'(scale_load[2]), 1);
        @(negedge clk);
        chk(scale_load[2] == 1'b0, "R8", "dc ch2 strobe is one clock", int'(scale_load[2]), 0);

        // R9: halt overrides full-on channels within two clocks
        dc_mask = '1;
        repeat (4) @(negedge clk);
        chk(gate == '1, "R9", "all full-on before halt", int'(gate), int'({NCH{1'b1}}));
        halt = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(gate == '0, "R9", "gates two clocks after halt", int'(gate), 0);
        window(FLEN);
        chk(hi_cnt[0] == 0, "R9", "ch0 high count while halted", hi_cnt[0], 0);
        chk(hi_cnt[17] == 0, "R9", "ch17 high count while halted", hi_cnt[17], 0);

        // R8: halted block strobes PWM channel two clocks after request
        dc_mask = '0;
        scale_req = 1'b1;
        @(negedge clk);
        scale_req = 1'b0;
        chk(scale_load[0] == 1'b0, "R8", "halted ch0 strobe one clock after", int'(scale_load[0]), 0);
        @(negedge clk);
        chk(scale_load[0] == 1'b1, "R8", "halted ch0 strobe two clocks after", int'(scale_load[0]), 1);

        // R9: release resumes duty operation
        halt = 1'b0;
        set_duty(0, 90);
        repeat (2 * FLEN) @(negedge clk);
        window(FLEN);
        chk(hi_cnt[0] == 90, "R9", "ch0 high count after release", hi_cnt[0], 90);

        done = 1'b1;
        finish_run();
    end

endmodule